// File: doc/BRIEF.md
# Host Bridge Memory Address Decoder

This block sits at the host side of a host-to-PCI bridge and decides, for every host memory access, whether the bridge claims it and forwards it to PCI or leaves it to main memory. It looks at a 36-bit physical address and a read/write flag. It then returns a claim bit and a small region code that says which window matched. The outputs are combinational from the address and the stored configuration, so the decision is ready in the cycle the address is presented.

The configuration is held in a few registers that are loaded through a single-cycle write port. Below 1 MB the decision comes from a legacy map of programmable blocks. Each block carries a two-bit attribute that gates reads and writes separately. Above 1 MB the block checks the following windows, highest priority first:
- an interrupt-controller window
- a high boot-ROM window just below 4 GB
- two power-of-two gaps aligned to 1 MB (a frame-buffer gap and a general memory gap)
- a high gap bounded by an inclusive start and end, given in megabytes

Top module: `hb_addr_decode`

## Requirements
- R1: Each legacy block has a 2-bit attribute. Bit 0 set claims reads and bit 1 set claims writes, so 0 = disabled, 1 = read-only, 2 = write-only, 3 = read/write. An access in a block whose attribute bit for its direction is clear is not claimed.
- R2: Addresses 0x00000 to 0x7FFFF are never claimed, whatever the configuration.
- R3: The legacy blocks are numbered as follows, and block k uses bits [2k+1:2k] of config index 0. The range 0xA0000 to 0xBFFFF is never claimed.
  - Block 0 is 0x80000 to 0x9FFFF.
  - Blocks 1 to 8 are the 16 KB blocks from 0xC0000 upward.
  - Blocks 9 to 12 are the 16 KB blocks from 0xE0000 upward.
  - Block 13 is 0xF0000 to 0xFFFFF.
- R4: After reset, block 13 is read/write when PRIMARY is 1 and disabled when PRIMARY is 0. All other blocks, gaps and windows are disabled.
- R5: The frame-buffer gap (index 1) has three fields: bit 0 enable, bits [3:1] size code, bits [31:16] base in MB. The size code n gives a size of 2^n MB for n from 0 to 5, and codes 6 and 7 act as 32 MB. The base bits below the size are ignored. A hit gives region 2.
- R6: The memory gap (index 2) uses the same field layout and size rule as R5. A hit gives region 3.
- R7: The high gap has its enable in bit 0 of index 3 and its start MB in bits [31:16] of index 3. Its end MB is in bits [31:16] of index 4. The gap covers start to end inclusive, gives region 4, and matches nothing when start is greater than end.
- R8: When index 5 bit 0 is set, 0xFEC00000 to 0xFEC0FFFF is claimed with region 5.
- R9: When index 5 bit 1 is set, 0xFFE00000 to 0xFFFFFFFF is claimed with region 6.
- R10: Below 1 MB only the legacy map applies. Above 1 MB the priority is region 5, then 6, 2, 3 and 4.
- R11: Region 1 marks a legacy claim. An unclaimed access reports region 0, and a claimed access reports a region from 1 to 6.
- R12: A configuration write takes effect from the clock edge where cfg_we is high. Writes to indices 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| addr | input | 36 | Host physical address |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| claim | output | 1 | Bridge claims the access |
| region | output | 3 | Code of the matching window, 0 if none |

## Verification
The bench sweeps every legacy block through all four attributes. At each step it probes the first and last byte of all fourteen blocks in both directions. A wrong block split or a swapped read/write bit would leak a claim into a neighbouring block or the wrong direction.

For each gap the bench tries all eight size codes with a deliberately misaligned base, probing one MB either side of each edge. A design that failed to mask the base, or that grew the size past 32 MB, would misplace an edge.

The remaining checks cover four things:
- the inclusive ends of the high gap and the empty case where start is greater than end
- overlapping windows, where the priority decides the region
- the hole at 0xA0000
- the reset-time boot block

// File: rtl/hb_addr_decode.sv
module hb_addr_decode #(
  parameter int ADDR_W  = 36,
  parameter bit PRIMARY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  output logic              claim,
  output logic [2:0]        region
);
  localparam int MB_W = ADDR_W - 20;
  localparam int NBLK = 14;
  localparam logic [2*NBLK-1:0] LEG_RST = PRIMARY ? (2*NBLK)'(3) << (2*NBLK-2) : '0;
  localparam logic [ADDR_W-17:0] APIC_PAGE = 'hFEC0;
  localparam logic [ADDR_W-22:0] BIOS_TOP  = 'h7FF;

  logic [2*NBLK-1:0] legacy_attr;
  logic              fb_en, mg_en, hg_en, apic_en, hbios_en;
  logic [2:0]        fb_sz, mg_sz;
  logic [MB_W-1:0]   fb_base, mg_base, hg_start, hg_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legacy_attr <= LEG_RST;
      fb_en <= 1'b0; fb_sz <= '0; fb_base <= '0;
      mg_en <= 1'b0; mg_sz <= '0; mg_base <= '0;
      hg_en <= 1'b0; hg_start <= '0; hg_end <= '0;
      apic_en <= 1'b0; hbios_en <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_idx)
        3'd0: legacy_attr <= cfg_wdata[2*NBLK-1:0];
        3'd1: begin fb_en <= cfg_wdata[0]; fb_sz <= cfg_wdata[3:1]; fb_base <= cfg_wdata[16 +: MB_W]; end
        3'd2: begin mg_en <= cfg_wdata[0]; mg_sz <= cfg_wdata[3:1]; mg_base <= cfg_wdata[16 +: MB_W]; end
        3'd3: begin hg_en <= cfg_wdata[0]; hg_start <= cfg_wdata[16 +: MB_W]; end
        3'd4: hg_end <= cfg_wdata[16 +: MB_W];
        3'd5: begin apic_en <= cfg_wdata[0]; hbios_en <= cfg_wdata[1]; end
        default: ;
      endcase
    end
  end

  function automatic logic gap_hit(input logic [MB_W-1:0] mb, input logic [MB_W-1:0] base,
                                   input logic [2:0] sz);
    logic [MB_W-1:0] m;
    m = {MB_W{1'b1}} << ((sz > 3'd5) ? 3'd5 : sz);
    return ((mb ^ base) & m) == '0;
  endfunction

  logic [MB_W-1:0] mb;
  logic            low1m, blk_ok, leg_hit, apic_m, bios_m, fb_m, mg_m, hg_m;
  logic [3:0]      blk;
  logic [1:0]      attr;

  assign mb    = addr[ADDR_W-1:20];
  assign low1m = (mb == '0);

  always_comb begin
    blk    = 4'd0;
    blk_ok = 1'b1;
    case (addr[19:16])
      4'h8, 4'h9: blk = 4'd0;
      4'hC, 4'hD: blk = 4'd1 + {1'b0, addr[16], addr[15:14]};
      4'hE:       blk = 4'd9 + {2'b00, addr[15:14]};
      4'hF:       blk = 4'd13;
      default:    blk_ok = 1'b0;
    endcase
  end

  assign attr    = legacy_attr[{blk, 1'b0} +: 2];
  assign leg_hit = blk_ok && (is_write ? attr[1] : attr[0]);
  assign apic_m  = apic_en  && (addr[ADDR_W-1:16] == APIC_PAGE);
  assign bios_m  = hbios_en && (addr[ADDR_W-1:21] == BIOS_TOP);
  assign fb_m    = fb_en && gap_hit(mb, fb_base, fb_sz);
  assign mg_m    = mg_en && gap_hit(mb, mg_base, mg_sz);
  assign hg_m    = hg_en && (mb >= hg_start) && (mb <= hg_end);

  always_comb begin
    if (low1m)       region = leg_hit ? 3'd1 : 3'd0;
    else if (apic_m) region = 3'd5;
    else if (bios_m) region = 3'd6;
    else if (fb_m)   region = 3'd2;
    else if (mg_m)   region = 3'd3;
    else if (hg_m)   region = 3'd4;
    else             region = 3'd0;
  end

  assign claim = (region != 3'd0);

  AST_LOW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1:19] == '0) |-> !claim); // R2
  AST_VGA_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1:17] == 'd5) |-> !claim); // R3
  AST_LEGACY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 3'd1) |-> low1m); // R10
  AST_APIC_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    apic_m && !low1m |-> claim && region == 3'd5); // R8
  AST_REGION_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> region <= 3'd6); // R11
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable(legacy_attr) && $stable(hg_start) && $stable(apic_en)); // R12
endmodule

// File: tb/test_hb_addr_decode.sv
`timescale 1ns/1ps
module test_hb_addr_decode;
  logic        clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, is_write = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [35:0] addr = '0;
  logic        claim;
  logic [2:0]  region;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  hb_addr_decode i_hb_addr_decode (.clk, .rst_n, .cfg_we, .cfg_idx, .cfg_wdata,
                                   .addr, .is_write, .claim, .region);

  logic [27:0] s_leg;
  logic        s_fb_en, s_mg_en, s_hg_en, s_apic, s_bios;
  logic [2:0]  s_fb_sz, s_mg_sz;
  logic [15:0] s_fb_base, s_mg_base, s_hs, s_he;

  function automatic bit in_gap(longint mb, longint base, int sz);
    int n = (sz > 5) ? 5 : sz;
    longint size = longint'(1) << n;
    longint lo = base - (base % size);
    return mb >= lo && mb < lo + size;
  endfunction

  function automatic logic [2:0] model(logic [35:0] a, bit w);
    int b = -1;
    logic [1:0] at;
    longint la = longint'(a);
    longint mb = la >> 20;
    if (la < 64'h100000) begin
      if (la >= 64'h80000 && la < 64'hA0000) b = 0;
      else if (la >= 64'hC0000 && la < 64'hE0000) b = 1 + int'((la - 64'hC0000) / 64'h4000);
      else if (la >= 64'hE0000 && la < 64'hF0000) b = 9 + int'((la - 64'hE0000) / 64'h4000);
      else if (la >= 64'hF0000) b = 13;
      if (b < 0) return 3'd0;
      at = s_leg[2*b +: 2];
      return (w ? at[1] : at[0]) ? 3'd1 : 3'd0;
    end
    if (s_apic && la >= 64'hFEC00000 && la <= 64'hFEC0FFFF) return 3'd5;
    if (s_bios && la >= 64'hFFE00000 && la <= 64'hFFFFFFFF) return 3'd6;
    if (s_fb_en && in_gap(mb, longint'(s_fb_base), int'(s_fb_sz))) return 3'd2;
    if (s_mg_en && in_gap(mb, longint'(s_mg_base), int'(s_mg_sz))) return 3'd3;
    if (s_hg_en && mb >= longint'(s_hs) && mb <= longint'(s_he)) return 3'd4;
    return 3'd0;
  endfunction

  task automatic cfg_write(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (idx)
      3'd0: s_leg = d[27:0];
      3'd1: begin s_fb_en = d[0]; s_fb_sz = d[3:1]; s_fb_base = d[31:16]; end
      3'd2: begin s_mg_en = d[0]; s_mg_sz = d[3:1]; s_mg_base = d[31:16]; end
      3'd3: begin s_hg_en = d[0]; s_hs = d[31:16]; end
      3'd4: s_he = d[31:16];
      3'd5: begin s_apic = d[0]; s_bios = d[1]; end
      default: ;
    endcase
  endtask

  task automatic probe(input logic [35:0] a, input bit w, input string tag);
    logic [2:0] e;
    @(negedge clk);
    addr = a; is_write = w;
    #5;
    e = model(a, w);
    tests++;
    if (region !== e || claim !== (e != 3'd0)) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0d region=%0d claim=%0d expected region=%0d claim=%0d",
               tag, a, w, region, claim, e, e != 3'd0);
    end
  endtask

  function automatic logic [35:0] blk_base(int b);
    if (b == 0) return 36'h80000;
    if (b <= 8) return 36'hC0000 + 36'(b - 1) * 36'h4000;
    if (b <= 12) return 36'hE0000 + 36'(b - 9) * 36'h4000;
    return 36'hF0000;
  endfunction

  function automatic logic [35:0] blk_last(int b);
    if (b == 0) return 36'h9FFFF;
    if (b == 13) return 36'hFFFFF;
    return blk_base(b) + 36'h3FFF;
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    s_leg = 28'hC000000;
    s_fb_en = 0; s_mg_en = 0; s_hg_en = 0; s_apic = 0; s_bios = 0;
    s_fb_sz = 0; s_mg_sz = 0; s_fb_base = 0; s_mg_base = 0; s_hs = 0; s_he = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4 reset defaults: boot block claimed, nothing else
    probe(36'hF0000, 0, "R4");
    probe(36'hFFFFF, 1, "R4");
    probe(36'hC0000, 0, "R4");
    probe(36'h0FEC00000, 0, "R4");
    probe(36'h0FFFFFFF0, 0, "R4");
    probe(36'h000100000, 1, "R4");

    // R1 R3 attribute sweep over every block
    for (int at = 0; at < 4; at++)
      for (int b = 0; b < 14; b++) begin
        cfg_write(3'd0, 32'(at) << (2 * b));
        for (int p = 0; p < 14; p++)
          for (int w = 0; w < 2; w++) begin
            probe(blk_base(p), w[0], "R1");
            probe(blk_last(p), w[0], "R3");
          end
      end

    // R2 R3 fixed areas with everything open
    cfg_write(3'd0, 32'h0FFFFFFF);
    for (int w = 0; w < 2; w++) begin
      probe(36'h00000, w[0], "R2");
      probe(36'h7FFFF, w[0], "R2");
      probe(36'hA0000, w[0], "R3");
      probe(36'hBFFFF, w[0], "R3");
    end

    // R5 R6 gap sizes with misaligned base
    for (int g = 1; g <= 2; g++)
      for (int sz = 0; sz < 8; sz++) begin
        int n = (sz > 5) ? 5 : sz;
        int lo = 'h0A5F - ('h0A5F % (1 << n));
        cfg_write(3'(g), {16'h0A5F, 12'h0, 3'(sz), 1'b1});
        probe({16'(lo - 1), 20'h0}, 0, g == 1 ? "R5" : "R6");
        probe({16'(lo), 20'h0}, 1, g == 1 ? "R5" : "R6");
        probe({16'(lo + (1 << n) - 1), 20'hFFFFF}, 0, g == 1 ? "R5" : "R6");
        probe({16'(lo + (1 << n)), 20'h0}, 1, g == 1 ? "R5" : "R6");
        cfg_write(3'(g), 32'h0);
      end

    // R7 high gap inclusive bounds and empty case
    cfg_write(3'd3, {16'h8000, 15'h0, 1'b1});
    cfg_write(3'd4, {16'hFFFF, 16'h0});
    probe(36'h7FFFFFFFF, 0, "R7");
    probe(36'h800000000, 0, "R7");
    probe(36'hFFFFFFFFF, 1, "R7");
    cfg_write(3'd3, {16'h9000, 15'h0, 1'b1});
    cfg_write(3'd4, {16'h8FFF, 16'h0});
    probe(36'h8FFF00000, 0, "R7");
    probe(36'h900000000, 1, "R7");

    // R8 R9 R10 windows and priority over overlapping gaps
    cfg_write(3'd3, {16'h0800, 15'h0, 1'b1});
    cfg_write(3'd4, {16'h0FFF, 16'h0});
    cfg_write(3'd1, {16'h0FE0, 12'h0, 3'd5, 1'b1});
    cfg_write(3'd2, {16'h0F00, 12'h0, 3'd5, 1'b1});
    probe(36'h0FEC00000, 0, "R10");
    probe(36'h0FFE00000, 0, "R10");
    cfg_write(3'd5, 32'h1);
    probe(36'h0FEC00000, 0, "R8");
    probe(36'h0FEC0FFFF, 1, "R8");
    probe(36'h0FEC10000, 0, "R8");
    probe(36'h0FFE00000, 0, "R9");
    cfg_write(3'd5, 32'h3);
    probe(36'h0FFE00000, 1, "R9");
    probe(36'h0FFFFFFFF, 0, "R9");
    probe(36'h0FFDFFFFF, 0, "R10");
    probe(36'h0F0000000, 0, "R10");
    probe(36'h0E0000000, 0, "R10");
    probe(36'h0FEC00000, 1, "R11");
    probe(36'h000F00000, 0, "R11");
    cfg_write(3'd1, {16'h0000, 12'h0, 3'd5, 1'b1});
    probe(36'h00000000, 0, "R10");
    probe(36'h000A0000, 1, "R10");
    probe(36'h00100000, 0, "R10");

    // R12 unused indices change nothing
    cfg_write(3'd6, 32'hFFFFFFFF);
    cfg_write(3'd7, 32'h00000000);
    probe(36'h0FEC00000, 0, "R12");
    probe(36'h0FFE00000, 0, "R12");
    probe(36'hC4000, 1, "R12");
    probe(36'h0C0000000, 0, "R12");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule